// File: doc/BRIEF.md
# Load-Use Hazard Interlock Unit

This block is the hazard-detection logic of a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback) that already forwards every result it can. Forwarding cannot serve one case. A value fetched by a load exists only once the memory stage ends, so an instruction that reads it in execute in the very next cycle cannot receive it. The unit compares the destination register of a load now in execute with the source registers that the decode-stage instruction actually reads. On a match it holds the program counter and the fetch/decode register for one cycle and selects a bubble into the decode/execute register. The dependent instruction then leaves decode one cycle late, and the memory/writeback forwarding path supplies the loaded value.

All other read-after-write cases go to forwarding. After the single stall the dependent instruction and the ones behind it go ahead with no further stalls, so the stalled instruction pays exactly one extra cycle. A store whose data register is the load's destination also stalls, because no separate store-data forwarding path is assumed. Register zero is hard-wired, so a load that targets it never causes a stall. A one-cycle guard register stops a second stall from following the first directly. The guard is a parameter option.

Top module: `lu_hazard_unit`

## Requirements
- R1: While `rst_n` is low the outputs are idle: `pc_we`=1, `ifid_we`=1, `idex_bubble`=0, whatever the other inputs are.
- R2: When `ex_is_load`=1, `ex_dst`≠0, `id_src_a_used`=1 and `id_src_a`=`ex_dst`, and no stall took place in the previous cycle, the unit stalls in the same cycle: `idex_bubble`=1, `pc_we`=0, `ifid_we`=0.
- R3: The same stall occurs for the second source (`id_src_b_used`=1, `id_src_b`=`ex_dst`). This source covers store data, so a store that depends on the load stalls.
- R4: A load whose destination is register 0 never stalls, even when decode reads register 0.
- R5: A source whose use flag is 0 never causes a stall, even if its number equals the load destination. A load followed by independent instructions does not stall.
- R6: When `ex_is_load`=0, no stall occurs, whatever the register numbers are.
- R7: `pc_we` and `ifid_we` are always equal, and each is the inverse of `idex_bubble`.
- R8: A stall lasts exactly one cycle. In the cycle after a stall cycle there is no stall, even if the inputs still describe a hazard.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ex_is_load | input | 1 | Execute stage holds a load |
| ex_dst | input | REG_ADDR_W | Destination register of the execute-stage instruction |
| id_src_a | input | REG_ADDR_W | First source register number in decode |
| id_src_a_used | input | 1 | Decode instruction reads the first source |
| id_src_b | input | REG_ADDR_W | Second source register number in decode (also store data) |
| id_src_b_used | input | 1 | Decode instruction reads the second source |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| idex_bubble | output | 1 | Load a bubble (zeroed control fields) into decode/execute |

## Verification
The hazard decision is combinational, so a wrong compare or qualifier shows up at the three outputs in the same cycle as the offending input pattern. The guard register is the only state. If it is corrupted, a stall is either suppressed or repeated, and this appears on the cycle after a stall. The sweep therefore applies every load/destination/source/use combination of a three-bit register space back to back, so that each vector also tests the guard against the one before it. Short instruction sequences follow the sweep: dependent chains, independent instructions, a dependent store and a load to register 0.

// File: rtl/lu_pkg.sv
`timescale 1ns/1ps
package lu_pkg;
   localparam int unsigned NUM_SRC = 2;

   typedef struct packed {
      logic pc_we;
      logic ifid_we;
      logic bubble;
   } lu_ctrl_t;

   localparam lu_ctrl_t CTRL_RUN   = '{pc_we: 1'b1, ifid_we: 1'b1, bubble: 1'b0};
   localparam lu_ctrl_t CTRL_STALL = '{pc_we: 1'b0, ifid_we: 1'b0, bubble: 1'b1};
endpackage

// File: rtl/lu_src_cmp.sv
`timescale 1ns/1ps
module lu_src_cmp #(
   parameter int unsigned AW = 5
) (
   input  logic [AW-1:0] src,
   input  logic          used,
   input  logic [AW-1:0] dst,
   output logic          hit
);
   always_comb hit = used && (src == dst);
endmodule

// File: rtl/lu_ld_qual.sv
`timescale 1ns/1ps
module lu_ld_qual #(
   parameter int unsigned AW        = 5,
   parameter bit          ZERO_HARD = 1'b1
) (
   input  logic          is_load,
   input  logic [AW-1:0] dst,
   output logic          live
);
   generate
      if (ZERO_HARD) begin : g_zero_masked
         always_comb live = is_load && (dst != '0);
      end else begin : g_zero_plain
         logic unused_dst;
         always_comb unused_dst = ^dst;
         always_comb live = is_load;
      end
   endgenerate
endmodule

// File: rtl/lu_stall_gen.sv
`timescale 1ns/1ps
module lu_stall_gen
   import lu_pkg::*;
#(
   parameter int unsigned NSRC  = 2,
   parameter bit          GUARD = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            live,
   input  logic [NSRC-1:0] hits,
   output lu_ctrl_t        ctrl
);
   logic raw;
   logic stall;

   always_comb raw = live && (|hits);

   generate
      if (GUARD) begin : g_guard
         logic stalled_q;
         always_ff @(posedge clk) begin
            if (!rst_n) stalled_q <= 1'b0;
            else        stalled_q <= stall;
         end
         always_comb stall = rst_n && raw && !stalled_q;
      end else begin : g_noguard
         always_comb stall = rst_n && raw;
      end
   endgenerate

   always_comb ctrl = stall ? CTRL_STALL : CTRL_RUN;
endmodule

// File: rtl/lu_hazard_unit.sv
`timescale 1ns/1ps
module lu_hazard_unit
   import lu_pkg::*;
#(
   parameter int unsigned REG_ADDR_W         = 5,
   parameter bit          ZERO_REG_HARDWIRED = 1'b1,
   parameter bit          SINGLE_STALL_GUARD = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ex_is_load,
   input  logic [REG_ADDR_W-1:0] ex_dst,
   input  logic [REG_ADDR_W-1:0] id_src_a,
   input  logic                  id_src_a_used,
   input  logic [REG_ADDR_W-1:0] id_src_b,
   input  logic                  id_src_b_used,
   output logic                  pc_we,
   output logic                  ifid_we,
   output logic                  idex_bubble
);
   localparam int unsigned NSRC = NUM_SRC;

   generate
      if (REG_ADDR_W < 1 || REG_ADDR_W > 8) begin : g_bad_width
         $error("lu_hazard_unit: REG_ADDR_W must lie in 1..8");
      end
   endgenerate

   logic [REG_ADDR_W-1:0] src_vec [NSRC];
   logic [NSRC-1:0]       use_vec;
   logic [NSRC-1:0]       hit_vec;
   logic                  load_live;
   lu_ctrl_t              ctrl;

   always_comb begin
      src_vec[0] = id_src_a;
      src_vec[1] = id_src_b;
      use_vec    = {id_src_b_used, id_src_a_used};
   end

   lu_ld_qual #(.AW(REG_ADDR_W), .ZERO_HARD(ZERO_REG_HARDWIRED)) u_qual (
      .is_load (ex_is_load),
      .dst     (ex_dst),
      .live    (load_live)
   );

   generate
      for (genvar i = 0; i < NSRC; i++) begin : g_cmp
         lu_src_cmp #(.AW(REG_ADDR_W)) u_cmp (
            .src  (src_vec[i]),
            .used (use_vec[i]),
            .dst  (ex_dst),
            .hit  (hit_vec[i])
         );
      end
   endgenerate

   lu_stall_gen #(.NSRC(NSRC), .GUARD(SINGLE_STALL_GUARD)) u_gen (
      .clk   (clk),
      .rst_n (rst_n),
      .live  (load_live),
      .hits  (hit_vec),
      .ctrl  (ctrl)
   );

   always_comb begin
      pc_we       = ctrl.pc_we;
      ifid_we     = ctrl.ifid_we;
      idex_bubble = ctrl.bubble;
   end
endmodule

// File: rtl/lu_hazard_checker.sv
`timescale 1ns/1ps
module lu_hazard_checker #(
   parameter int unsigned REG_ADDR_W         = 5,
   parameter bit          ZERO_REG_HARDWIRED = 1'b1,
   parameter bit          SINGLE_STALL_GUARD = 1'b1
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  ex_is_load,
   input logic [REG_ADDR_W-1:0] ex_dst,
   input logic [REG_ADDR_W-1:0] id_src_a,
   input logic                  id_src_a_used,
   input logic [REG_ADDR_W-1:0] id_src_b,
   input logic                  id_src_b_used,
   input logic                  pc_we,
   input logic                  ifid_we,
   input logic                  idex_bubble
);
   logic prev_stall;
   always_ff @(posedge clk) begin
      if (!rst_n) prev_stall <= 1'b0;
      else        prev_stall <= idex_bubble;
   end

   always @(negedge clk) begin
      if (!rst_n) begin
         p_reset_idle_r1: assert (pc_we && ifid_we && !idex_bubble)
            else $error("R1 outputs not idle in reset");
      end
   end

   p_stall_src_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_is_load && ex_dst != '0 && id_src_a_used && id_src_a == ex_dst && !prev_stall)
      |-> (idex_bubble && !pc_we && !ifid_we));

   p_stall_src_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_is_load && ex_dst != '0 && id_src_b_used && id_src_b == ex_dst && !prev_stall)
      |-> (idex_bubble && !pc_we && !ifid_we));

   p_unused_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((!id_src_a_used || id_src_a != ex_dst) && (!id_src_b_used || id_src_b != ex_dst))
      |-> !idex_bubble);

   p_no_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !ex_is_load |-> !idex_bubble);

   p_consistent_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_we == ifid_we) && (pc_we != idex_bubble));

   generate
      if (ZERO_REG_HARDWIRED) begin : g_zero_chk
         p_zero_dst_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (ex_dst == '0) |-> !idex_bubble);
      end
      if (SINGLE_STALL_GUARD) begin : g_single_chk
         p_single_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
            idex_bubble |=> !idex_bubble);
      end
   endgenerate
endmodule

bind lu_hazard_unit lu_hazard_checker #(
   .REG_ADDR_W         (REG_ADDR_W),
   .ZERO_REG_HARDWIRED (ZERO_REG_HARDWIRED),
   .SINGLE_STALL_GUARD (SINGLE_STALL_GUARD)
) u_lu_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .ex_is_load    (ex_is_load),
   .ex_dst        (ex_dst),
   .id_src_a      (id_src_a),
   .id_src_a_used (id_src_a_used),
   .id_src_b      (id_src_b),
   .id_src_b_used (id_src_b_used),
   .pc_we         (pc_we),
   .ifid_we       (ifid_we),
   .idex_bubble   (idex_bubble)
);

// File: tb/test_lu_hazard_unit.sv
`timescale 1ns/1ps
module test_lu_hazard_unit;
   localparam int unsigned AW = 3;
   localparam int unsigned NR = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ex_is_load = 1'b0;
   logic [AW-1:0] ex_dst = '0;
   logic [AW-1:0] id_src_a = '0;
   logic          id_src_a_used = 1'b0;
   logic [AW-1:0] id_src_b = '0;
   logic          id_src_b_used = 1'b0;
   logic          pc_we, ifid_we, idex_bubble;

   int  n_vec = 0;
   int  n_bad = 0;
   bit  model_prev = 1'b0;
   bit  finished = 1'b0;

   always #5 clk = ~clk;

   lu_hazard_unit #(.REG_ADDR_W(AW)) i_lu_hazard_unit (
      .clk(clk), .rst_n(rst_n), .ex_is_load(ex_is_load), .ex_dst(ex_dst),
      .id_src_a(id_src_a), .id_src_a_used(id_src_a_used),
      .id_src_b(id_src_b), .id_src_b_used(id_src_b_used),
      .pc_we(pc_we), .ifid_we(ifid_we), .idex_bubble(idex_bubble)
   );

   task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: {pc_we,ifid_we,bubble} actual=%b expected=%b (load=%0b dst=%0d a=%0d/%0b b=%0d/%0b)",
                  req, got, exp, ex_is_load, ex_dst, id_src_a, id_src_a_used, id_src_b, id_src_b_used);
      end
   endtask

   // Drives one decode/execute pairing at a negedge, checks mid-cycle, models the guard.
   task automatic apply(input bit ld, input int dst, input int a, input bit au,
                        input int b, input bit bu);
      bit hit_a, hit_b, live, exp_stall;
      string req;
      @(negedge clk);
      ex_is_load = ld; ex_dst = AW'(dst);
      id_src_a = AW'(a); id_src_a_used = au;
      id_src_b = AW'(b); id_src_b_used = bu;
      #2;
      live  = ld && (dst != 0);
      hit_a = au && (a == dst);
      hit_b = bu && (b == dst);
      exp_stall = live && (hit_a || hit_b) && !model_prev;
      if (!ld)                     req = "R6";
      else if (dst == 0)           req = "R4";
      else if (!(hit_a || hit_b))  req = "R5";
      else if (model_prev)         req = "R8";
      else if (hit_a)              req = "R2";
      else                         req = "R3";
      check(req, {pc_we, ifid_we, idex_bubble},
            exp_stall ? 3'b001 : 3'b110);
      check("R7", {pc_we == ifid_we, pc_we != idex_bubble, 1'b0}, 3'b110);
      model_prev = exp_stall;
   endtask

   initial begin
      // R1: hazard pattern presented during reset must not stall
      ex_is_load = 1'b1; ex_dst = 3'd2; id_src_a = 3'd2; id_src_a_used = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk); #2;
      check("R1", {pc_we, ifid_we, idex_bubble}, 3'b110);
      @(negedge clk); #2;
      check("R1", {pc_we, ifid_we, idex_bubble}, 3'b110);
      @(negedge clk); rst_n = 1'b1;
      ex_is_load = 1'b0;

      // Exhaustive sweep back to back (covers R2..R8)
      for (int ld = 0; ld < 2; ld++)
         for (int d = 0; d < NR; d++)
            for (int a = 0; a < NR; a++)
               for (int b = 0; b < NR; b++)
                  for (int u = 0; u < 4; u++)
                     apply(ld[0], d, a, u[0], b, u[1]);

      // Sequences: LW r1; SUB uses r1 -> one stall (R2), bubble in EX, next deps forward
      apply(0, 0, 0, 0, 0, 0);
      apply(1, 1, 1, 1, 5, 1);   // R2 stall
      apply(1, 1, 1, 1, 5, 1);   // R8 held inputs, no second stall
      apply(0, 0, 1, 1, 7, 1);   // bubble in EX: R6
      apply(0, 4, 1, 1, 7, 1);   // SUB in EX, AND in ID: R6
      // Dependent store: data register in second source (R3)
      apply(1, 3, 6, 1, 3, 1);
      apply(0, 0, 6, 1, 3, 1);
      // Independent instructions after a load (R5)
      apply(1, 2, 4, 1, 5, 1);
      apply(1, 2, 2, 0, 2, 0);
      // Load to r0 then use of r0 (R4)
      apply(1, 0, 0, 1, 0, 1);
      // Two loads in a row, second depends on first, then user of second (R2, R2)
      apply(1, 1, 1, 1, 0, 0);
      apply(0, 0, 1, 1, 0, 0);
      apply(1, 2, 2, 1, 0, 0);

      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_vec++; n_bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule